// File: doc/BRIEF.md
# Multicycle Instruction Cycle Sequencer with Interrupt Entry

This block is the control unit and register set of a small accumulator machine. It runs each instruction as a chain of register transfers among a program counter, a memory address register, a memory buffer register, an instruction register and an accumulator. All memory traffic goes through one synchronous port that has separate read and write strobes and a ready input. Every instruction passes through a fetch phase. An optional indirect phase resolves a pointer to the operand address. An execute phase follows. At the end of the instruction, an interrupt check decides whether to run an interrupt phase.

The interrupt request is level sensitive and is gated by an internal enable flag. When the sequencer takes an interrupt, it stores the return address in a fixed save word through the buffer register, clears the enable flag and continues at a fixed handler address. A return instruction reads the save word back into the program counter and sets the enable flag again. A small instruction set of load, store, add, jump, interrupt enable, interrupt disable and return is enough to drive every phase.

Top module: `icyc_seq`

## Requirements
- R1: While reset is high, the program counter, instruction register and accumulator clear to zero, interrupts are disabled and neither memory strobe is asserted.
- R2: A fetch reads the word at the program counter and increments the program counter by one. The first read after reset is at address 0.
- R3: An instruction word holds the opcode in bits 15:12, the indirect flag in bit 11 and the address field in bits 10:0. Opcodes are 0 no-op, 1 load, 2 store, 3 add, 4 jump, 5 enable interrupts, 6 disable interrupts and 7 return from interrupt. Codes 8 to 15 act as no-ops.
- R4: For opcodes 1 to 4 with bit 11 set, the sequencer first reads the word at the address field and uses its bits 10:0 as the effective address.
- R5: Load copies the word at the effective address into the accumulator. Add adds that word to the accumulator, modulo 2^16.
- R6: Store writes the accumulator to the effective address. Jump loads the program counter with the effective address.
- R7: The sequencer enters the interrupt phase only after an instruction completes while the request is high and interrupts are enabled. While interrupts are disabled, the request has no effect.
- R8: The interrupt phase writes the return address (the address of the next sequential instruction) to address 0 with interrupts already disabled. The next fetch is then at address 1.
- R9: Return from interrupt loads the program counter from the word at address 0 and enables interrupts.
- R10: A read or write keeps its strobe, address and write data unchanged until a cycle in which ready is high. Read and write are never asserted together.
- R11: Opcode 5 enables interrupts and opcode 6 disables them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 11 | Memory address, driven from the address register |
| mem_rd | output | 1 | Read strobe, held until ready |
| mem_wr | output | 1 | Write strobe, held until ready |
| mem_wdata | output | 16 | Write data, driven from the buffer register |
| mem_rdata | input | 16 | Read data, valid when ready is high |
| mem_ready | input | 1 | Completes the pending access in this cycle |
| irq | input | 1 | Level-sensitive interrupt request |
| pc_out | output | 11 | Program counter |
| acc_out | output | 16 | Accumulator |
| int_en | output | 1 | Interrupt enable flag |

## Verification
The hardest case to reach is an interrupt that is pending but masked, followed by an instruction that unmasks it. The bench raises the request right after reset and runs a program that keeps interrupts disabled through several direct and indirect accesses. Only the enable instruction lets the save cycle start. After the return, the bench raises the request again under a disable instruction, so that a second save happens only when interrupts are enabled once more. The memory model inserts varying wait states, and the bench compares every write in order against an expected queue, so any save at the wrong time shows up as a mismatch.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP = 4'd0,
    OP_LDA = 4'd1,
    OP_STA = 4'd2,
    OP_ADD = 4'd3,
    OP_JMP = 4'd4,
    OP_EI  = 4'd5,
    OP_DI  = 4'd6,
    OP_RTI = 4'd7
  } op_e;

  typedef enum logic [3:0] {
    S_FADDR, S_FREAD, S_FLOAD, S_DEC,
    S_IREAD, S_IADDR, S_EXEC, S_OREAD,
    S_ALU,   S_WRITE, S_RREAD, S_CHK,
    S_ISAVE
  } st_e;

  typedef enum logic [2:0] {MAR_HOLD, MAR_PC, MAR_IR, MAR_MBR, MAR_SAVE} mar_sel_e;
  typedef enum logic [1:0] {MBR_HOLD, MBR_MEM, MBR_ACC, MBR_PC} mbr_sel_e;
  typedef enum logic [2:0] {PC_HOLD, PC_INC, PC_MAR, PC_MEM, PC_VEC} pc_sel_e;
  typedef enum logic [1:0] {ACC_HOLD, ACC_LOAD, ACC_ADD} acc_sel_e;
  typedef enum logic [1:0] {IE_HOLD, IE_SET, IE_CLR} ie_sel_e;

  typedef struct packed {
    mar_sel_e mar;
    mbr_sel_e mbr;
    pc_sel_e  pc;
    acc_sel_e acc;
    ie_sel_e  ie;
    logic     ir_ld;
  } ctl_t;

endpackage

// File: rtl/icyc_dpath.sv
module icyc_dpath
  import icyc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 11,
  parameter int SAVE_ADDR  = 0,
  parameter int VEC_ADDR   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] acc,
  output logic              ie
);

  localparam logic [ADDR_W-1:0] SAVE_A = ADDR_W'(SAVE_ADDR);
  localparam logic [ADDR_W-1:0] VEC_A  = ADDR_W'(VEC_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else begin
      case (ctl.pc)
        PC_INC:  pc <= pc + 1'b1;
        PC_MAR:  pc <= mar;
        PC_MEM:  pc <= mem_rdata[ADDR_W-1:0];
        PC_VEC:  pc <= VEC_A;
        default: pc <= pc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mar <= '0;
    end else begin
      case (ctl.mar)
        MAR_PC:   mar <= pc;
        MAR_IR:   mar <= ir[ADDR_W-1:0];
        MAR_MBR:  mar <= mbr[ADDR_W-1:0];
        MAR_SAVE: mar <= SAVE_A;
        default:  mar <= mar;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mbr <= '0;
    end else begin
      case (ctl.mbr)
        MBR_MEM: mbr <= mem_rdata;
        MBR_ACC: mbr <= acc;
        MBR_PC:  mbr <= DATA_W'(pc);
        default: mbr <= mbr;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir <= '0;
    end else if (ctl.ir_ld) begin
      ir <= mbr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else begin
      case (ctl.acc)
        ACC_LOAD: acc <= mbr;
        ACC_ADD:  acc <= acc + mbr;
        default:  acc <= acc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie <= 1'b0;
    end else begin
      case (ctl.ie)
        IE_SET:  ie <= 1'b1;
        IE_CLR:  ie <= 1'b0;
        default: ie <= ie;
      endcase
    end
  end

endmodule

// File: rtl/icyc_ctrl.sv
module icyc_ctrl
  import icyc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opc,
  input  logic             ind,
  input  logic             ie,
  input  logic             irq,
  input  logic             mem_ready,
  output ctl_t             ctl,
  output st_e              st,
  output logic             mem_rd,
  output logic             mem_wr
);

  st_e nxt;
  op_e op;
  logic uses_ea;

  assign op      = op_e'(opc);
  assign uses_ea = (op == OP_LDA) || (op == OP_STA) || (op == OP_ADD) || (op == OP_JMP);

  always_ff @(posedge clk) begin
    if (rst) st <= S_FADDR;
    else     st <= nxt;
  end

  always_comb begin
    ctl = '{mar: MAR_HOLD, mbr: MBR_HOLD, pc: PC_HOLD, acc: ACC_HOLD, ie: IE_HOLD, ir_ld: 1'b0};
    nxt = st;
    case (st)
      S_FADDR: begin
        ctl.mar = MAR_PC;
        nxt     = S_FREAD;
      end
      S_FREAD: if (mem_ready) begin
        ctl.mbr = MBR_MEM;
        ctl.pc  = PC_INC;
        nxt     = S_FLOAD;
      end
      S_FLOAD: begin
        ctl.ir_ld = 1'b1;
        nxt       = S_DEC;
      end
      S_DEC: begin
        ctl.mar = MAR_IR;
        nxt     = (uses_ea && ind) ? S_IREAD : S_EXEC;
      end
      S_IREAD: if (mem_ready) begin
        ctl.mbr = MBR_MEM;
        nxt     = S_IADDR;
      end
      S_IADDR: begin
        ctl.mar = MAR_MBR;
        nxt     = S_EXEC;
      end
      S_EXEC: begin
        case (op)
          OP_LDA, OP_ADD: nxt = S_OREAD;
          OP_STA: begin
            ctl.mbr = MBR_ACC;
            nxt     = S_WRITE;
          end
          OP_JMP: begin
            ctl.pc = PC_MAR;
            nxt    = S_CHK;
          end
          OP_EI: begin
            ctl.ie = IE_SET;
            nxt    = S_CHK;
          end
          OP_DI: begin
            ctl.ie = IE_CLR;
            nxt    = S_CHK;
          end
          OP_RTI: begin
            ctl.mar = MAR_SAVE;
            nxt     = S_RREAD;
          end
          default: nxt = S_CHK;
        endcase
      end
      S_OREAD: if (mem_ready) begin
        ctl.mbr = MBR_MEM;
        nxt     = S_ALU;
      end
      S_ALU: begin
        ctl.acc = (op == OP_LDA) ? ACC_LOAD : ACC_ADD;
        nxt     = S_CHK;
      end
      S_WRITE: if (mem_ready) nxt = S_CHK;
      S_RREAD: if (mem_ready) begin
        ctl.pc = PC_MEM;
        ctl.ie = IE_SET;
        nxt    = S_CHK;
      end
      S_CHK: begin
        if (ie && irq) begin
          ctl.ie  = IE_CLR;
          ctl.mbr = MBR_PC;
          ctl.mar = MAR_SAVE;
          nxt     = S_ISAVE;
        end else begin
          nxt = S_FADDR;
        end
      end
      S_ISAVE: if (mem_ready) begin
        ctl.pc = PC_VEC;
        nxt    = S_FADDR;
      end
      default: nxt = S_FADDR;
    endcase
  end

  assign mem_rd = (st == S_FREAD) || (st == S_IREAD) || (st == S_OREAD) || (st == S_RREAD);
  assign mem_wr = (st == S_WRITE) || (st == S_ISAVE);

  // R10: never read and write in the same cycle
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr));

  // R7: with interrupts masked, the end-of-instruction check always returns to fetch
  a_r7_masked: assert property (@(posedge clk) disable iff (rst)
    (st == S_CHK && !ie) |=> (st == S_FADDR));

endmodule

// File: rtl/icyc_seq.sv
module icyc_seq
  import icyc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = DATA_W - OPC_W - 1,
  parameter int SAVE_ADDR = 0,
  parameter int VEC_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  input  logic              irq,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] acc_out,
  output logic              int_en
);

  ctl_t              ctl;
  st_e               st;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mbr;
  logic [DATA_W-1:0] ir;

  icyc_dpath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SAVE_ADDR(SAVE_ADDR), .VEC_ADDR(VEC_ADDR)
  ) u_dpath (
    .clk(clk), .rst(rst), .ctl(ctl), .mem_rdata(mem_rdata),
    .pc(pc_out), .mar(mar), .mbr(mbr), .ir(ir), .acc(acc_out), .ie(int_en)
  );

  icyc_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .opc(ir[DATA_W-1 -: OPC_W]), .ind(ir[ADDR_W]),
    .ie(int_en), .irq(irq), .mem_ready(mem_ready),
    .ctl(ctl), .st(st), .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mbr;

  // R1: reset leaves the machine state cleared
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pc_out == '0 && acc_out == '0 && !int_en && !mem_rd && !mem_wr));

  // R10: a pending access keeps its address until ready
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && !mem_ready) |=> $stable(mem_addr));

  // R10: a pending read stays asserted
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_ready) |=> mem_rd);

  // R10: a pending write keeps strobe and data
  a_r10_wr_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_wdata)));

  // R2: a completed fetch read advances the program counter by one
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (st == S_FREAD && mem_ready) |=> (pc_out == $past(pc_out) + 1'b1));

  // R8: the save cycle targets the save word with interrupts masked
  a_r8_save_slot: assert property (@(posedge clk) disable iff (rst)
    (st == S_ISAVE) |-> (mem_addr == ADDR_W'(SAVE_ADDR) && !int_en));

  // R8: after the save the program counter points at the handler
  a_r8_vector: assert property (@(posedge clk) disable iff (rst)
    (st == S_ISAVE && mem_ready) |=> (pc_out == ADDR_W'(VEC_ADDR)));

endmodule

// File: tb/icyc_seq_bench.sv
module icyc_seq_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic [10:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        mem_ready;
  logic        irq;
  logic [10:0] pc_out;
  logic [15:0] acc_out;
  logic        int_en;

  icyc_seq u_icyc_seq (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .irq(irq), .pc_out(pc_out), .acc_out(acc_out), .int_en(int_en)
  );

  always #10 clk = ~clk;

  typedef struct {
    int          addr;
    logic [15:0] data;
    string       tag;
  } wr_item_t;

  wr_item_t    exp_q[$];
  logic [15:0] mem [0:63];
  int n_checks = 0;
  int n_fail   = 0;
  int wait_left;
  int lat_seq;
  int writes_seen;
  bit first_read;
  bit after_save;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input int op, input bit ind, input int a);
    logic [3:0]  o = op[3:0];
    logic [10:0] f = a[10:0];
    return {o, ind, f};
  endfunction

  // driver: expected write traffic, in order
  task automatic push_write(input int a, input logic [15:0] d, input string tag);
    wr_item_t it;
    it.addr = a; it.data = d; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic load_program();
    for (int k = 0; k < 64; k++) mem[k] = 16'h0;
    // R3 encoding: opcode [15:12], indirect [11], address [10:0]
    mem[0]  = enc(4, 0, 16);   // jump to main
    mem[1]  = enc(3, 0, 40);   // handler: add
    mem[2]  = enc(2, 0, 41);   // handler: store
    mem[3]  = enc(7, 0, 0);    // return
    mem[16] = enc(1, 0, 32);
    mem[17] = enc(3, 1, 33);
    mem[18] = enc(2, 0, 35);
    mem[19] = enc(2, 1, 36);
    mem[20] = enc(4, 1, 38);
    mem[21] = enc(1, 0, 32);   // skipped by the jump
    mem[22] = enc(3, 0, 39);
    mem[23] = enc(5, 0, 0);
    mem[24] = enc(6, 0, 0);
    mem[25] = enc(2, 0, 42);
    mem[26] = enc(3, 0, 32);
    mem[27] = enc(2, 0, 43);
    mem[28] = enc(5, 0, 0);
    mem[29] = enc(4, 0, 29);
    mem[32] = 16'd5;
    mem[33] = 16'd34;
    mem[34] = 16'd7;
    mem[36] = 16'd37;
    mem[38] = 16'd22;
    mem[39] = 16'h0100;
    mem[40] = 16'd3;
  endtask

  // monitor: memory model with wait states plus scoreboard compare
  task automatic mem_step();
    if (mem_ready) begin
      mem_ready = 1'b0;
    end else if (mem_rd || mem_wr) begin
      if (wait_left > 0) begin
        wait_left--;
      end else begin
        mem_ready = 1'b1;
        lat_seq++;
        wait_left = lat_seq % 3;
        if (mem_rd) begin
          mem_rdata = mem[mem_addr[5:0]];
          if (first_read) begin
            chk(mem_addr == 11'd0, "R2 first fetch address", mem_addr, 0);
            first_read = 1'b0;
          end
          if (after_save) begin
            chk(mem_addr == 11'd1, "R8 fetch after save", mem_addr, 1);
            after_save = 1'b0;
          end
        end else begin
          mem[mem_addr[5:0]] = mem_wdata;
          writes_seen++;
          chk(!mem_rd, "R10 write without read", mem_rd, 0);
          if (exp_q.size() == 0) begin
            chk(1'b0, "R7 unexpected write", mem_addr, 0);
          end else begin
            wr_item_t it = exp_q.pop_front();
            chk(mem_addr == it.addr[10:0], {it.tag, " address"}, mem_addr, it.addr);
            chk(mem_wdata == it.data, {it.tag, " data"}, mem_wdata, it.data);
          end
          if (mem_addr == 11'd0) begin
            chk(!int_en, "R8 enable cleared at save", int_en, 0);
            irq = 1'b0;
            after_save = 1'b1;
          end
          if (mem_addr == 11'd42) irq = 1'b1;
        end
      end
    end
  endtask

  initial begin
    int cyc;
    rst = 1'b1; irq = 1'b0; mem_ready = 1'b0; mem_rdata = '0;
    wait_left = 1; lat_seq = 0; writes_seen = 0;
    first_read = 1'b1; after_save = 1'b0;
    load_program();
    repeat (3) @(negedge clk);
    chk(pc_out == 0, "R1 pc", pc_out, 0);
    chk(acc_out == 0, "R1 acc", acc_out, 0);
    chk(!int_en, "R1 enable", int_en, 0);
    chk(!mem_rd && !mem_wr, "R1 strobes", {mem_rd, mem_wr}, 0);

    push_write(35, 16'h000C, "R4/R5/R6 direct store");
    push_write(37, 16'h000C, "R4 indirect store");
    push_write(0,  16'd24,   "R7/R8/R11 first save");
    push_write(41, 16'h010F, "R5 handler store 1");
    push_write(42, 16'h010F, "R9 after return");
    push_write(43, 16'h0114, "R7/R11 masked store");
    push_write(0,  16'd29,   "R8/R11 second save");
    push_write(41, 16'h0117, "R5 handler store 2");

    rst = 1'b0;
    irq = 1'b1;   // pending from the start, masked until enable
    cyc = 0;
    while (writes_seen < 8 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      mem_step();
    end
    if (cyc >= 20000) chk(1'b0, "watchdog", cyc, 0);
    repeat (100) begin
      @(negedge clk);
      mem_step();
    end
    chk(exp_q.size() == 0, "R7 all writes seen", exp_q.size(), 0);
    chk(acc_out == 16'h0117, "R3/R5 final accumulator", acc_out, 16'h0117);
    chk(int_en, "R9 enable after return", int_en, 1);
    chk(pc_out == 11'd29 || pc_out == 11'd30, "R6 jump loop", pc_out, 29);

    rst = 1'b1;
    mem_ready = 1'b0;
    repeat (2) @(negedge clk);
    chk(acc_out == 0, "R1 acc after rerun reset", acc_out, 0);
    chk(pc_out == 0, "R1 pc after rerun reset", pc_out, 0);
    chk(!int_en, "R1 enable after rerun reset", int_en, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule